// File: doc/BRIEF.md
# Calibrated Timekeeping Prescaler

This block sits between a free-running 32,768 Hz oscillator and the seconds counter of a real-time clock. Each pulse on `osc_tick` marks one oscillator period on the fast system clock. The block counts these pulses and produces a one-cycle `sec_pulse` once per second. It also produces a 512 Hz square wave from a separate divider stage. The oscillator stop bit `osc_halt` freezes every counter. When it is released, counting resumes from the value that was held.

Rate trimming works over a window of `WINDOW_S` seconds. In the final second of each window, the second period is changed by `CAL_STEP` × magnitude oscillator counts. It is shortened when the trim-direction bit is 1 and lengthened when that bit is 0. The 512 Hz stage never sees this adjustment.

A single pin, `aux_pin`, shows either the square wave or a static level, as chosen by a test-select bit. There is no streaming data path, so every port is a plain level or pulse with no handshake.

Top module: `rtc_prescaler`

## Requirements
- R1: With no trim in force, `sec_pulse` is high for exactly one clock cycle after every `IN_HZ` counted oscillator ticks. A counted tick is a cycle with `osc_tick`=1 and `osc_halt`=0. The pulse appears in the cycle after the clock edge that counts the final tick.
- R2: When `trim_ctrl[5]`=1, the last second of each window lasts `IN_HZ` − `CAL_STEP`×`trim_ctrl[4:0]` counted ticks.
- R3: When `trim_ctrl[5]`=0, the last second of each window lasts `IN_HZ` + `CAL_STEP`×`trim_ctrl[4:0]` counted ticks. A magnitude of 0 leaves that second at `IN_HZ` with either direction.
- R4: The internal square wave starts low. It inverts after every `IN_HZ`/(2×`TAP_HZ`) counted ticks, which gives 50% duty. This holds in every second, including trimmed ones.
- R5: `aux_pin` equals the square wave when `trim_ctrl[6]`=1 and equals `trim_ctrl[7]` when `trim_ctrl[6]`=0. The pin follows these bits combinationally, with no clock edge needed.
- R6: While `osc_halt`=1, `osc_tick` pulses are ignored. No `sec_pulse` occurs, the square wave holds, and all counts hold. After release, the current second completes after exactly its remaining ticks.
- R7: Clock cycles with `osc_tick`=0 do not advance any count. The second length is measured in ticks, not in clock cycles.
- R8: Reset (`rst_n`=0) clears `sec_pulse`, drives the square wave low, and zeroes the tick counts and the window position. The first trimmed second is therefore the `WINDOW_S`-th second after reset.
- R9: The trim recurs in every window. Seconds 1 to `WINDOW_S`−1 of the next window again last `IN_HZ` ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | One-cycle enable per oscillator period |
| osc_halt | input | 1 | 1 stops all counting (oscillator stop bit) |
| trim_ctrl | input | 8 | [7] static pin level, [6] test select, [5] trim direction (1 = faster), [4:0] trim magnitude |
| sec_pulse | output | 1 | One-cycle pulse per second |
| aux_pin | output | 1 | Test square wave or static level |

## Verification
A wrong window position shows up only at the ports as a trimmed second landing in the wrong slot. Detecting it can take up to a full window of seconds, so each trim vector is followed through two complete windows. A wrong second count appears as a wrong gap between consecutive `sec_pulse` events. In contrast, a wrong square-wave phase becomes visible on `aux_pin` within one half-period. For that reason the pin is sampled at every half-period boundary across a trimmed second. Halt and idle-tick faults show up as a pulse arriving early when measured in counted ticks.

// File: rtl/presc_pkg.sv
package presc_pkg;
  // width of the trim magnitude field in the control byte
  localparam int unsigned TRIM_W = 5;

  // control byte layout: level, test select, direction, magnitude
  typedef struct packed {
    logic              pin_level;
    logic              test_sel;
    logic              trim_fast;
    logic [TRIM_W-1:0] trim_mag;
  } trim_ctrl_t;
endpackage

// File: rtl/presc_tap_div.sv
// Square-wave stage: inverts after HALF counted ticks.
module presc_tap_div #(
  parameter int unsigned HALF = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  output logic wave
);
  localparam int unsigned W = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [W-1:0] LAST = W'(HALF - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      wave <= 1'b0;
    end else if (step) begin
      if (cnt == LAST) begin
        cnt  <= '0;
        wave <= ~wave;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/presc_sec_div.sv
// Second counter: wraps after `period` counted ticks, pulses once per wrap.
module presc_sec_div #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [CNT_W-1:0] period,
  output logic             wrap,
  output logic             tick
);
  logic [CNT_W-1:0] cnt;

  // >= so that a shorter period chosen mid-second still ends it at once
  assign wrap = step && (cnt >= (period - CNT_W'(1)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= wrap;
      if (wrap)      cnt <= '0;
      else if (step) cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/presc_cal_window.sv
// Tracks the position inside the trim window and picks the current period.
module presc_cal_window
  import presc_pkg::*;
#(
  parameter int unsigned IN_HZ    = 32768,
  parameter int unsigned WINDOW_S = 64,
  parameter int unsigned CAL_STEP = 2,
  parameter int unsigned CNT_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrap,
  input  logic              trim_fast,
  input  logic [TRIM_W-1:0] trim_mag,
  output logic [CNT_W-1:0]  period
);
  localparam logic [CNT_W-1:0] BASE = CNT_W'(IN_HZ);
  localparam logic [CNT_W-1:0] STEP = CNT_W'(CAL_STEP);

  logic             last_sec;
  logic [CNT_W-1:0] shift;

  generate
    if (WINDOW_S > 1) begin : g_window
      localparam int unsigned WIN_W = $clog2(WINDOW_S);
      localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WINDOW_S - 1);
      logic [WIN_W-1:0] win_idx;

      always_ff @(posedge clk) begin
        if (!rst_n)         win_idx <= '0;
        else if (wrap)      win_idx <= (win_idx == WIN_LAST) ? '0 : win_idx + 1'b1;
      end
      assign last_sec = (win_idx == WIN_LAST);
    end else begin : g_every
      // one-second window: every second is trimmed
      assign last_sec = 1'b1;
    end
  endgenerate

  assign shift = STEP * CNT_W'(trim_mag);

  always_comb begin
    if (!last_sec)      period = BASE;
    else if (trim_fast) period = BASE - shift;
    else                period = BASE + shift;
  end
endmodule

// File: rtl/rtc_prescaler.sv
// Top: calibrated 1 Hz prescaler with square-wave test pin.
module rtc_prescaler
  import presc_pkg::*;
#(
  parameter int unsigned IN_HZ    = 32768,
  parameter int unsigned TAP_HZ   = 512,
  parameter int unsigned WINDOW_S = 64,
  parameter int unsigned CAL_STEP = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_tick,
  input  logic       osc_halt,
  input  logic [7:0] trim_ctrl,
  output logic       sec_pulse,
  output logic       aux_pin
);
  localparam int unsigned MAX_MAG = (1 << TRIM_W) - 1;
  localparam int unsigned HALF    = IN_HZ / (2 * TAP_HZ);
  localparam int unsigned CNT_W   = $clog2(IN_HZ + CAL_STEP * MAX_MAG + 1);

  trim_ctrl_t       ctrl;
  logic             step;
  logic             tap_wave;
  logic             sec_wrap;
  logic [CNT_W-1:0] period;

  assign ctrl = trim_ctrl_t'(trim_ctrl);
  assign step = osc_tick & ~osc_halt;

  presc_tap_div #(.HALF(HALF)) tap_i (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (step),
    .wave  (tap_wave)
  );

  presc_cal_window #(
    .IN_HZ    (IN_HZ),
    .WINDOW_S (WINDOW_S),
    .CAL_STEP (CAL_STEP),
    .CNT_W    (CNT_W)
  ) win_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wrap      (sec_wrap),
    .trim_fast (ctrl.trim_fast),
    .trim_mag  (ctrl.trim_mag),
    .period    (period)
  );

  presc_sec_div #(.CNT_W(CNT_W)) sec_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (step),
    .period (period),
    .wrap   (sec_wrap),
    .tick   (sec_pulse)
  );

  assign aux_pin = ctrl.test_sel ? tap_wave : ctrl.pin_level;
endmodule

// File: rtl/rtc_prescaler_chk.sv
module rtc_prescaler_chk #(
  parameter int unsigned IN_HZ    = 32768,
  parameter int unsigned CAL_STEP = 2
) (
  input logic clk,
  input logic rst_n,
  input logic osc_tick,
  input logic osc_halt,
  input logic sec_pulse,
  input logic tap_wave
);
  localparam int unsigned SPAN = CAL_STEP * 31;
  localparam int unsigned CW   = $clog2(IN_HZ + SPAN + 2);
  localparam logic [CW-1:0] LO = CW'(IN_HZ - SPAN);
  localparam logic [CW-1:0] HI = CW'(IN_HZ + SPAN);

  logic          cstep;
  logic [CW-1:0] gap;

  assign cstep = osc_tick & ~osc_halt;

  always_ff @(posedge clk) begin
    if (!rst_n)         gap <= '0;
    else if (sec_pulse) gap <= cstep ? CW'(1) : '0;
    else if (cstep)     gap <= gap + 1'b1;
  end

  // R1
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse |=> !sec_pulse);

  // R6
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    osc_halt |=> (!sec_pulse && $stable(tap_wave)));

  // R7
  idle_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_tick |=> (!sec_pulse && $stable(tap_wave)));

  // R4
  wave_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tap_wave != $past(tap_wave)) |-> $past(osc_tick && !osc_halt));

  // R2
  period_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse |-> (gap >= LO && gap <= HI));
endmodule

bind rtc_prescaler rtc_prescaler_chk #(.IN_HZ(IN_HZ), .CAL_STEP(CAL_STEP)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .osc_tick  (osc_tick),
  .osc_halt  (osc_halt),
  .sec_pulse (sec_pulse),
  .tap_wave  (tap_wave)
);

// File: tb/rtc_prescaler_tb_top.sv
`timescale 1ns/1ps
module rtc_prescaler_tb_top;
  localparam int IN_HZ = 256;
  localparam int TAP_HZ = 8;
  localparam int WIN = 4;
  localparam int HALF = 16;
  // {trim_fast, magnitude, expected length of the trimmed second}
  localparam int VEC [6][3] = '{
    '{0, 0, 256}, '{1, 5, 246}, '{0, 5, 266},
    '{1, 31, 194}, '{0, 31, 318}, '{1, 1, 254}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc_tick = 1'b0;
  logic osc_halt = 1'b0;
  logic [7:0] trim_ctrl = 8'h40;
  logic sec_pulse;
  logic aux_pin;

  int n_chk = 0;
  int n_fail = 0;
  int steps = 0;
  int tot = 0;
  int last_gap = 0;
  bit seen = 1'b0;

  always #2.5 clk = ~clk;

  rtc_prescaler #(.IN_HZ(IN_HZ), .TAP_HZ(TAP_HZ), .WINDOW_S(WIN), .CAL_STEP(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .osc_halt(osc_halt),
    .trim_ctrl(trim_ctrl), .sec_pulse(sec_pulse), .aux_pin(aux_pin)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input bit tk, input bit hl);
    osc_tick = tk;
    osc_halt = hl;
    @(posedge clk);
    @(negedge clk);
    if (tk && !hl) begin steps++; tot++; end
    seen = sec_pulse;
    if (sec_pulse) begin last_gap = steps; steps = 0; end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    osc_tick = 1'b0;
    osc_halt = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    steps = 0;
    tot = 0;
  endtask

  task automatic next_second(input int every, output int gap);
    int i = 0;
    do begin
      cyc((i % every) == 0, 1'b0);
      i++;
    end while (!seen && i < 4000);
    gap = seen ? last_gap : -1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int g;
    // R8 and R5: reset state at the ports
    repeat (2) @(negedge clk);
    check("R8 pulse in reset", sec_pulse, 0);
    trim_ctrl = 8'h40;
    #1 check("R8 wave low in reset", aux_pin, 0);
    trim_ctrl = 8'h80;
    #1 check("R5 static level 1", aux_pin, 1);
    trim_ctrl = 8'h00;
    #1 check("R5 static level 0", aux_pin, 0);
    do_reset();

    // vector table: two full windows per trim setting
    for (int v = 0; v < 6; v++) begin
      do_reset();
      trim_ctrl = {1'b0, 1'b1, VEC[v][0] != 0, 5'(VEC[v][1])};
      for (int s = 0; s < 2 * WIN; s++) begin
        next_second(1, g);
        if (s % WIN == WIN - 1)
          check(VEC[v][0] != 0 ? "R2 trimmed second" : "R3 trimmed second", g, VEC[v][2]);
        else if (s >= WIN)
          check("R9 untrimmed second next window", g, IN_HZ);
        else
          check("R1 untrimmed second", g, IN_HZ);
      end
    end

    // R4: square wave phase across a trimmed (slow 31) second
    do_reset();
    trim_ctrl = 8'h5F;
    while (tot < WIN * IN_HZ + 62) begin
      cyc(1'b1, 1'b0);
      if (tot % HALF == 0) check("R4 wave phase", aux_pin, (tot / HALF) % 2);
    end

    // R5: pin follows static level while the divider runs
    trim_ctrl = 8'h80;
    cyc(1'b1, 1'b0);
    check("R5 level high while running", aux_pin, 1);
    trim_ctrl = 8'h00;
    #1 check("R5 level low while running", aux_pin, 0);

    // R6: halt mid-second, then resume
    do_reset();
    trim_ctrl = 8'h40;
    repeat (100) cyc(1'b1, 1'b0);
    begin
      int pulses = 0;
      int moved = 0;
      for (int k = 0; k < 60; k++) begin
        cyc(1'b1, 1'b1);
        if (seen) pulses++;
        if (aux_pin != 1'b0) moved++;
      end
      check("R6 no pulse while halted", pulses, 0);
      check("R6 wave held while halted", moved, 0);
    end
    next_second(1, g);
    check("R6 resume from held count", g, IN_HZ);

    // R7: ticks every third cycle
    do_reset();
    trim_ctrl = 8'h40;
    next_second(3, g);
    check("R7 sparse ticks", g, IN_HZ);

    // R8: reset mid-second restarts the count
    repeat (100) cyc(1'b1, 1'b0);
    do_reset();
    next_second(1, g);
    check("R8 restart after reset", g, IN_HZ);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule